// File: doc/BRIEF.md
# System Power Mode Controller

This block sequences a processor subsystem between five operating conditions: a deep sleep with the processor and bus clocks stopped, an idle "doze" mode running everything from one slow or crystal oscillator, a crystal start-up transition, a slow running mode on the crystal with the PLL off, and a normal running mode on the PLL. Software chooses the target by writing a two-bit mode request. The controller walks the state machine toward that target on its own, waiting on oscillator and PLL readiness. It also handles the wake-up path from sleep.

Each state is named and reported on `cur_mode`:
- **PM_SLEEP (0)**: clocks stopped.
- **PM_DOZE (1)**: reset state.
- **PM_XTAL (2)**: crystal start-up.
- **PM_SLOW (3)**: crystal-clocked run.
- **PM_PLLW (4)**: waiting for PLL lock.
- **PM_NORMAL (5)**: PLL-clocked run.

The allowed transitions are:
- DOZE→SLEEP (sleep entry)
- SLEEP→DOZE (wake)
- DOZE→XTAL (start-up)
- XTAL→SLOW or XTAL→PLLW (start-up done)
- XTAL→DOZE (abort)
- SLOW→PLLW (speed-up)
- PLLW→NORMAL (lock)
- PLLW→SLOW and NORMAL→SLOW (slow-down)
- SLOW, PLLW and NORMAL→DOZE (drop to idle)

Every clock-source change goes through a break-before-make sequence. The DRAM self-refresh request stays raised whenever external memory cannot be used.

The processor and bus clocks share one switch, so `core_clk_en` and `bus_clk_en` always move together. The controller clock has its own switch. An IRQ or FIQ arriving in sleep brings the system back to doze on the next edge. At the same time it rewrites a stored sleep request into a doze request, with no software write needed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and right after it, `cur_mode` is 1 (doze), `req_mode` is 1, `dram_sref` is 1, and the system clock is enabled on source code 1 (crystal).
- R2: The controller enters sleep only from doze, and only in a cycle where `req_mode` is 0 and `cpu_wfi` is 1. Otherwise it stays in doze, unless the request is 2 or 3.
- R3: Once sleep has settled, `core_clk_en` and `bus_clk_en` are 0. `ctl_clk_en` is 1, with `ctl_src` equal to the source doze was using when sleep was entered.
- R4: An `irq` or `fiq` in sleep moves `cur_mode` to doze on the next edge. At that edge a stored request of 0 becomes 1, unless `req_wr` is high in the same cycle, in which case the written value wins.
- R5: Once doze has settled, the system clock and the controller clock both run from source 0 (low-frequency oscillator) when `doze_lf_sel` is 1, and from source 1 (crystal) when it is 0.
- R6: A request of 2 (slow) or 3 (normal) in doze enters the crystal state. That state is left once `xtal_ready` is high or once the count of cycles spent there reaches `xtal_tmo`. A request below 2 aborts back to doze.
- R7: Once slow has settled, the system clock runs from source 1 and `pll_en` is 0.
- R8: Normal is entered only from the PLL-wait state in a cycle with `pll_lock` high. In both states `pll_en` is 1. Once settled, normal clocks the system from source 2 (PLL) and PLL-wait clocks it from source 1.
- R9: A clock source output changes only while its enable is low, both in that cycle and in the one before. An enable never rises in a cycle where its source changes.
- R10: `dram_sref` is 1 in every state other than slow and normal. In slow and normal it clears only once the system clock has settled on its target.
- R11: In slow, PLL-wait and normal, a request below 2 returns to doze. A request of 2 in PLL-wait or normal goes to slow, and a request of 3 in slow goes to PLL-wait.
- R12: `cur_mode` encodes sleep=0, doze=1, crystal=2, slow=3, PLL-wait=4, normal=5. `req_mode` encodes sleep=0, doze=1, slow=2, normal=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Software write strobe for the mode request |
| req_wdata | input | 2 | Mode request value written by software |
| cpu_wfi | input | 1 | Processor is waiting for an interrupt |
| irq | input | 1 | Normal interrupt wake request |
| fiq | input | 1 | Fast interrupt wake request |
| doze_lf_sel | input | 1 | Doze source choice: 1 low-frequency, 0 crystal |
| xtal_ready | input | 1 | Crystal oscillator reports stable |
| xtal_tmo | input | TMO_W | Crystal start-up timeout in cycles |
| pll_lock | input | 1 | PLL reports lock |
| req_mode | output | 2 | Stored mode request |
| cur_mode | output | 3 | Current controller state |
| sys_src | output | 2 | Processor and bus clock source select |
| core_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| ctl_src | output | 2 | Controller clock source select |
| ctl_clk_en | output | 1 | Controller clock enable |
| pll_en | output | 1 | PLL power-up request |
| xtal_en | output | 1 | Crystal oscillator power-up request |
| dram_sref | output | 1 | DRAM self-refresh request |

## Verification
The properties assume that `irq`, `fiq`, `cpu_wfi`, `xtal_ready` and `pll_lock` are synchronous to `clk`. They also assume `xtal_tmo` is steady while the crystal state counts. Both switches are assumed to use a gap of at least one cycle. The stimulus changes every input only at the falling edge. It alters the timeout and the doze source selection only rarely. Wake pulses are mixed with simultaneous software writes, so both the rewrite case and the priority case occur.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_SLEEP  = 3'd0,
        PM_DOZE   = 3'd1,
        PM_XTAL   = 3'd2,
        PM_SLOW   = 3'd3,
        PM_PLLW   = 3'd4,
        PM_NORMAL = 3'd5
    } pm_state_t;

    typedef enum logic [1:0] {
        RQ_SLEEP  = 2'd0,
        RQ_DOZE   = 2'd1,
        RQ_SLOW   = 2'd2,
        RQ_NORMAL = 2'd3
    } pm_req_t;

    typedef enum logic [1:0] {
        CK_LF   = 2'd0,
        CK_XTAL = 2'd1,
        CK_PLL  = 2'd2
    } ck_src_t;

    typedef struct packed {
        ck_src_t sys_src;
        logic    sys_on;
        ck_src_t ctl_src;
        logic    ctl_on;
        logic    pll_on;
        logic    xtal_on;
    } pm_ctrl_t;

    localparam int unsigned NUM_DOM = 2;
    localparam int unsigned DOM_SYS = 0;
    localparam int unsigned DOM_CTL = 1;

endpackage

// File: rtl/pmc_req_reg.sv
module pmc_req_reg
    import pwr_mode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  logic [1:0] wdata,
    input  logic    hw_wake,
    output pm_req_t req_q
);

    // Software write has priority over the hardware sleep-to-doze rewrite.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= RQ_DOZE;
        end else if (wr) begin
            req_q <= pm_req_t'(wdata);
        end else if (hw_wake && (req_q == RQ_SLEEP)) begin
            req_q <= RQ_DOZE;
        end
    end

endmodule

// File: rtl/pmc_xtal_timer.sv
module pmc_xtal_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    input  logic         ready,
    output logic         done
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = ready || (cnt_q >= limit);

endmodule

// File: rtl/pmc_clk_switch.sv
module pmc_clk_switch
    import pwr_mode_pkg::*;
#(
    parameter int unsigned GAP = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ck_src_t tgt_src,
    input  logic    tgt_on,
    output ck_src_t src_q,
    output logic    en_q,
    output logic    settled
);

    localparam int unsigned GAP_EFF = (GAP < 1) ? 1 : GAP;
    localparam int unsigned CW      = $clog2(GAP_EFF + 1);

    logic [CW-1:0] gap_q;

    // Break before make: drop enable, wait out the gap, move the select,
    // then raise the enable one cycle later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= CK_XTAL;
            en_q  <= 1'b1;
            gap_q <= '0;
        end else if (en_q) begin
            if (!tgt_on || (tgt_src != src_q)) begin
                en_q  <= 1'b0;
                gap_q <= CW'(GAP_EFF);
            end
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end else if (tgt_on) begin
            if (tgt_src != src_q) begin
                src_q <= tgt_src;
            end else begin
                en_q <= 1'b1;
            end
        end
    end

    assign settled = tgt_on ? (en_q && (src_q == tgt_src)) : !en_q;

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_req_t   req,
    input  logic      wfi,
    input  logic      irq,
    input  logic      fiq,
    input  logic      doze_lf,
    input  logic      xtal_done,
    input  logic      pll_lock,
    input  logic      sys_settled,
    output pm_state_t state_q,
    output pm_ctrl_t  ctrl,
    output logic      hw_wake,
    output logic      xtal_run,
    output logic      sref_q
);

    pm_state_t state_d;
    ck_src_t   doze_src;
    ck_src_t   sleep_src_q;
    logic      run_req;
    logic      idle_req;

    assign doze_src = doze_lf ? CK_LF : CK_XTAL;
    assign run_req  = (req == RQ_SLOW) || (req == RQ_NORMAL);
    assign idle_req = !run_req;
    assign hw_wake  = (state_q == PM_SLEEP) && (irq || fiq);
    assign xtal_run = (state_q == PM_XTAL);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_SLEEP: begin
                if (irq || fiq) state_d = PM_DOZE;
            end
            PM_DOZE: begin
                if ((req == RQ_SLEEP) && wfi) state_d = PM_SLEEP;
                else if (run_req)             state_d = PM_XTAL;
            end
            PM_XTAL: begin
                if (idle_req)                  state_d = PM_DOZE;
                else if (xtal_done)            state_d = (req == RQ_NORMAL) ? PM_PLLW : PM_SLOW;
            end
            PM_SLOW: begin
                if (idle_req)                  state_d = PM_DOZE;
                else if (req == RQ_NORMAL)     state_d = PM_PLLW;
            end
            PM_PLLW: begin
                if (idle_req)                  state_d = PM_DOZE;
                else if (req == RQ_SLOW)       state_d = PM_SLOW;
                else if (pll_lock)             state_d = PM_NORMAL;
            end
            PM_NORMAL: begin
                if (idle_req)                  state_d = PM_DOZE;
                else if (req == RQ_SLOW)       state_d = PM_SLOW;
            end
            default: state_d = PM_DOZE;
        endcase
    end

    // State register, with the controller-clock source remembered for sleep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= PM_DOZE;
            sleep_src_q <= CK_XTAL;
        end else begin
            state_q <= state_d;
            if ((state_q == PM_DOZE) && (state_d == PM_SLEEP)) begin
                sleep_src_q <= doze_src;
            end
        end
    end

    // Self-refresh follows the next state so it rises in the leaving cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sref_q <= 1'b1;
        end else begin
            sref_q <= !(((state_d == PM_SLOW) || (state_d == PM_NORMAL))
                        && (state_d == state_q) && sys_settled);
        end
    end

    // Clock targets per state
    always_comb begin
        ctrl = '{sys_src: CK_XTAL, sys_on: 1'b1, ctl_src: CK_XTAL,
                 ctl_on: 1'b1, pll_on: 1'b0, xtal_on: 1'b1};
        unique case (state_q)
            PM_SLEEP: begin
                ctrl.sys_src = sleep_src_q;
                ctrl.sys_on  = 1'b0;
                ctrl.ctl_src = sleep_src_q;
                ctrl.xtal_on = (sleep_src_q == CK_XTAL);
            end
            PM_DOZE: begin
                ctrl.sys_src = doze_src;
                ctrl.ctl_src = doze_src;
                ctrl.xtal_on = (doze_src == CK_XTAL);
            end
            PM_XTAL: begin
                ctrl.sys_src = doze_src;
                ctrl.ctl_src = doze_src;
            end
            PM_SLOW: begin
                ctrl.sys_src = CK_XTAL;
            end
            PM_PLLW: begin
                ctrl.pll_on = 1'b1;
            end
            PM_NORMAL: begin
                ctrl.sys_src = CK_PLL;
                ctrl.pll_on  = 1'b1;
            end
            default: begin
                ctrl.sys_src = CK_XTAL;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned TMO_W  = 16,
    parameter int unsigned SW_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [1:0]       req_wdata,
    input  logic             cpu_wfi,
    input  logic             irq,
    input  logic             fiq,
    input  logic             doze_lf_sel,
    input  logic             xtal_ready,
    input  logic [TMO_W-1:0] xtal_tmo,
    input  logic             pll_lock,
    output logic [1:0]       req_mode,
    output logic [2:0]       cur_mode,
    output logic [1:0]       sys_src,
    output logic             core_clk_en,
    output logic             bus_clk_en,
    output logic [1:0]       ctl_src,
    output logic             ctl_clk_en,
    output logic             pll_en,
    output logic             xtal_en,
    output logic             dram_sref
);

    pm_req_t   req_q;
    pm_state_t state_q;
    pm_ctrl_t  ctrl;
    logic      hw_wake;
    logic      xtal_run;
    logic      xtal_done;
    logic      sref_q;

    ck_src_t   dom_tgt     [NUM_DOM];
    logic      dom_on      [NUM_DOM];
    ck_src_t   dom_src     [NUM_DOM];
    logic      dom_en      [NUM_DOM];
    logic      dom_settled [NUM_DOM];

    pmc_req_reg u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (req_wr),
        .wdata   (req_wdata),
        .hw_wake (hw_wake),
        .req_q   (req_q)
    );

    pmc_xtal_timer #(.W(TMO_W)) u_xtmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xtal_run),
        .limit (xtal_tmo),
        .ready (xtal_ready),
        .done  (xtal_done)
    );

    pmc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_q),
        .wfi         (cpu_wfi),
        .irq         (irq),
        .fiq         (fiq),
        .doze_lf     (doze_lf_sel),
        .xtal_done   (xtal_done),
        .pll_lock    (pll_lock),
        .sys_settled (dom_settled[DOM_SYS]),
        .state_q     (state_q),
        .ctrl        (ctrl),
        .hw_wake     (hw_wake),
        .xtal_run    (xtal_run),
        .sref_q      (sref_q)
    );

    assign dom_tgt[DOM_SYS] = ctrl.sys_src;
    assign dom_on[DOM_SYS]  = ctrl.sys_on;
    assign dom_tgt[DOM_CTL] = ctrl.ctl_src;
    assign dom_on[DOM_CTL]  = ctrl.ctl_on;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pmc_clk_switch #(.GAP(SW_GAP)) u_sw (
            .clk     (clk),
            .rst_n   (rst_n),
            .tgt_src (dom_tgt[d]),
            .tgt_on  (dom_on[d]),
            .src_q   (dom_src[d]),
            .en_q    (dom_en[d]),
            .settled (dom_settled[d])
        );
    end

    assign req_mode    = req_q;
    assign cur_mode    = state_q;
    assign sys_src     = dom_src[DOM_SYS];
    assign core_clk_en = dom_en[DOM_SYS];
    assign bus_clk_en  = dom_en[DOM_SYS];
    assign ctl_src     = dom_src[DOM_CTL];
    assign ctl_clk_en  = dom_en[DOM_CTL];
    assign pll_en      = ctrl.pll_on;
    assign xtal_en     = ctrl.xtal_on;
    assign dram_sref   = sref_q;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_wr,
    input logic       irq,
    input logic       fiq,
    input logic       cpu_wfi,
    input logic       pll_lock,
    input logic [1:0] req_mode,
    input logic [2:0] cur_mode,
    input logic [1:0] sys_src,
    input logic       core_clk_en,
    input logic       bus_clk_en,
    input logic [1:0] ctl_src,
    input logic       ctl_clk_en,
    input logic       pll_en,
    input logic       dram_sref
);

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && $past(cur_mode) != 3'd0) |-> ($past(cur_mode) == 3'd1 && $past(req_mode) == 2'd0 && $past(cpu_wfi))); // R2
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && (irq || fiq)) |=> (cur_mode == 3'd1)); // R4
    AST_REQ_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && (irq || fiq) && !req_wr && req_mode == 2'd0) |=> (req_mode == 2'd1)); // R4
    AST_SLOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd3 && $past(cur_mode) != 3'd3) |-> ($past(cur_mode) inside {3'd2, 3'd4, 3'd5})); // R6
    AST_SLOW_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd3) |-> !pll_en); // R7
    AST_NORMAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd5 && $past(cur_mode) != 3'd5) |-> ($past(cur_mode) == 3'd4 && $past(pll_lock))); // R8
    AST_SYS_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sys_src) |-> (!core_clk_en && !$past(core_clk_en))); // R9
    AST_CTL_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_src) |-> (!ctl_clk_en && !$past(ctl_clk_en))); // R9
    AST_SYS_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $stable(sys_src)); // R9
    AST_BUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clk_en == core_clk_en)); // R3
    AST_SREF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_mode == 3'd3 || cur_mode == 3'd5) |-> dram_sref); // R10
    AST_RUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode inside {3'd3, 3'd4, 3'd5}) && !req_mode[1]) |=> (cur_mode == 3'd1)); // R11

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_wr      (req_wr),
    .irq         (irq),
    .fiq         (fiq),
    .cpu_wfi     (cpu_wfi),
    .pll_lock    (pll_lock),
    .req_mode    (req_mode),
    .cur_mode    (cur_mode),
    .sys_src     (sys_src),
    .core_clk_en (core_clk_en),
    .bus_clk_en  (bus_clk_en),
    .ctl_src     (ctl_src),
    .ctl_clk_en  (ctl_clk_en),
    .pll_en      (pll_en),
    .dram_sref   (dram_sref)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

    localparam int TMO_W = 16;
    localparam int GAP   = 2;
    localparam int SET   = GAP + 6;
    localparam int S_SLEEP = 0, S_DOZE = 1, S_XTAL = 2, S_SLOW = 3, S_PLLW = 4, S_NORM = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wr = 1'b0;
    logic [1:0] req_wdata = 2'd0;
    logic cpu_wfi = 1'b0, irq = 1'b0, fiq = 1'b0, doze_lf_sel = 1'b0;
    logic xtal_ready = 1'b0, pll_lock = 1'b0;
    logic [TMO_W-1:0] xtal_tmo = 16'd5;
    logic [1:0] req_mode, sys_src, ctl_src;
    logic [2:0] cur_mode;
    logic core_clk_en, bus_clk_en, ctl_clk_en, pll_en, xtal_en, dram_sref;

    int total = 0, bad = 0;
    bit fin = 1'b0;
    int m_st, m_req, m_xcnt, m_slp, m_stay;
    string m_tag;
    logic lf_prev;
    logic [1:0] prev_sys_src;
    logic prev_core_en;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.TMO_W(TMO_W), .SW_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
        .cpu_wfi(cpu_wfi), .irq(irq), .fiq(fiq), .doze_lf_sel(doze_lf_sel),
        .xtal_ready(xtal_ready), .xtal_tmo(xtal_tmo), .pll_lock(pll_lock),
        .req_mode(req_mode), .cur_mode(cur_mode), .sys_src(sys_src),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .ctl_src(ctl_src),
        .ctl_clk_en(ctl_clk_en), .pll_en(pll_en), .xtal_en(xtal_en), .dram_sref(dram_sref)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_state(input int st, input int rq, input bit wfi,
                                      input bit wake, input bit xdone, input bit lock);
        case (st)
            S_SLEEP: return wake ? S_DOZE : S_SLEEP;
            S_DOZE:  return (rq == 0 && wfi) ? S_SLEEP : (rq >= 2 ? S_XTAL : S_DOZE);
            S_XTAL:  return (rq < 2) ? S_DOZE : (!xdone ? S_XTAL : (rq == 3 ? S_PLLW : S_SLOW));
            S_SLOW:  return (rq < 2) ? S_DOZE : (rq == 3 ? S_PLLW : S_SLOW);
            S_PLLW:  return (rq < 2) ? S_DOZE : (rq == 2 ? S_SLOW : (lock ? S_NORM : S_PLLW));
            default: return (rq < 2) ? S_DOZE : (rq == 2 ? S_SLOW : S_NORM);
        endcase
    endfunction

    function automatic string tag_for(input int from, input int to);
        if (from == S_SLEEP) return "R4 wake";
        if (to == S_SLEEP || (from == S_DOZE && to == S_DOZE)) return "R2 sleep entry";
        if (to == S_XTAL || from == S_XTAL) return "R6 crystal start";
        if (to == S_DOZE) return "R11 drop to doze";
        if (to == S_SLOW) return "R11 slow";
        return "R8 pll path";
    endfunction

    // Model update with the inputs now applied; result is the state after the next edge.
    task automatic model_advance();
        bit wake, xdone;
        int nst, nreq;
        wake  = (m_st == S_SLEEP) && (irq || fiq);
        xdone = xtal_ready || (m_xcnt >= int'(xtal_tmo));
        nst   = next_state(m_st, m_req, cpu_wfi, wake, xdone, pll_lock);
        nreq  = req_wr ? int'(req_wdata) : ((wake && m_req == 0) ? 1 : m_req);
        if (m_st == S_DOZE && nst == S_SLEEP) m_slp = doze_lf_sel ? 0 : 1;
        m_xcnt = (m_st == S_XTAL) ? ((m_xcnt < 65535) ? m_xcnt + 1 : m_xcnt) : 0;
        m_stay = (nst == m_st && doze_lf_sel == lf_prev) ? m_stay + 1 : 0;
        m_tag  = tag_for(m_st, nst);
        lf_prev = doze_lf_sel;
        m_st   = nst;
        m_req  = nreq;
    endtask

    task automatic check_all();
        int dz;
        dz = doze_lf_sel ? 0 : 1;
        check({m_tag, " R12 cur_mode"}, int'(cur_mode), m_st);
        check("R4 req_mode", int'(req_mode), m_req);
        if (sys_src != prev_sys_src) begin
            check("R9 sys en low at change", int'(core_clk_en), 0);
            check("R9 sys en low before change", int'(prev_core_en), 0);
        end
        prev_sys_src = sys_src;
        prev_core_en = core_clk_en;
        if (m_st != S_SLOW && m_st != S_NORM) check("R10 sref held", int'(dram_sref), 1);
        else if (m_stay >= SET) check("R10 sref cleared", int'(dram_sref), 0);
        if (m_stay >= SET) begin
            case (m_st)
                S_SLEEP: begin
                    check("R3 core gated", int'(core_clk_en), 0);
                    check("R3 bus gated", int'(bus_clk_en), 0);
                    check("R3 ctl on", int'(ctl_clk_en), 1);
                    check("R3 ctl src", int'(ctl_src), m_slp);
                end
                S_DOZE, S_XTAL: begin
                    check("R5 core on", int'(core_clk_en), 1);
                    check("R5 sys src", int'(sys_src), dz);
                    check("R5 ctl src", int'(ctl_src), dz);
                end
                S_SLOW: begin
                    check("R7 sys src", int'(sys_src), 1);
                    check("R7 pll off", int'(pll_en), 0);
                end
                S_PLLW: begin
                    check("R8 pll on", int'(pll_en), 1);
                    check("R8 sys src", int'(sys_src), 1);
                end
                default: begin
                    check("R8 pll on", int'(pll_en), 1);
                    check("R8 sys src", int'(sys_src), 2);
                    check("R8 core on", int'(core_clk_en), 1);
                end
            endcase
        end
    endtask

    task automatic tick();
        model_advance();
        @(negedge clk);
        check_all();
        req_wr = 1'b0;
        irq = 1'b0;
        fiq = 1'b0;
    endtask

    task automatic write_req(input int v);
        req_wr = 1'b1;
        req_wdata = 2'(v);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_st = S_DOZE; m_req = 1; m_xcnt = 0; m_slp = 1; m_stay = 0;
        m_tag = "R1"; lf_prev = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset mode", int'(cur_mode), S_DOZE);
        check("R1 reset sref", int'(dram_sref), 1);
        rst_n = 1'b1;
        check("R1 mode after release", int'(cur_mode), S_DOZE);
        check("R1 req after release", int'(req_mode), 1);
        check("R1 sys src", int'(sys_src), 1);
        check("R1 core en", int'(core_clk_en), 1);
        prev_sys_src = sys_src;
        prev_core_en = core_clk_en;

        // Sleep requested without wait-for-interrupt: stays in doze (R2)
        write_req(0);
        repeat (4) tick();
        cpu_wfi = 1'b1;
        repeat (SET + 2) tick();
        irq = 1'b1;                 // wake with rewrite (R4)
        tick();
        cpu_wfi = 1'b0;
        repeat (3) tick();

        // Sleep again on the low-frequency source, wake by FIQ plus a write (R4 priority)
        doze_lf_sel = 1'b1;
        repeat (SET + 2) tick();
        write_req(0);
        cpu_wfi = 1'b1;
        repeat (SET + 2) tick();
        cpu_wfi = 1'b0;
        fiq = 1'b1;
        req_wr = 1'b1;
        req_wdata = 2'd2;
        tick();

        // Crystal timeout path with no ready flag (R6)
        xtal_tmo = 16'd3;
        xtal_ready = 1'b0;
        repeat (SET + 6) tick();
        write_req(3);
        pll_lock = 1'b0;
        repeat (6) tick();
        pll_lock = 1'b1;
        repeat (SET + 2) tick();
        write_req(2);
        repeat (SET + 2) tick();
        write_req(1);
        repeat (SET + 2) tick();
        doze_lf_sel = 1'b0;

        // Constrained random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 12);
            req_wr = (r == 0);
            req_wdata = 2'($urandom % 4);
            cpu_wfi = ($urandom % 2) == 0;
            irq = ($urandom % 20) == 0;
            fiq = ($urandom % 40) == 0;
            xtal_ready = ($urandom % 8) == 0;
            pll_lock = ($urandom % 4) == 0;
            if (i % 500 == 0) xtal_tmo = 16'($urandom % 16);
            if (i % 700 == 0) doze_lf_sel = $urandom % 2;
            tick();
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule